// File: doc/BRIEF.md
# PLL Divider Configuration Holder

This block holds the four settings that program a clock synthesizer's divider chain. They are a 10-bit feedback divider, a 1-bit pre-divider select, and two 3-bit output post-divider codes (channel A and channel B). The settings can come from either of two places. One is a set of parallel configuration pins. The other is a small register bank that a serial-bus slave reaches through a byte-wide write/read strobe port.

A pin-mode input picks the source. While it is high, the synchronized pin values drive the dividers and the register bank is bypassed. The register bank can still be written and read in that time, and it keeps its own contents. The block registers the chosen ("effective") configuration and presents it to the divider logic. It raises a one-cycle change pulse in the same cycle that any effective field takes a new value.

The register bank also holds a read-only status byte, which reports the PLL lock indication through a two-flop synchronizer. Post-divider codes map as follows: 0 is ÷1, 1 is ÷2, 2 is ÷3, 3 is ÷4, 4 is ÷6, 5 is ÷8, 6 is ÷16 and 7 is output stopped low.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: After reset the effective outputs show feedback divider 0x064, pre-select 0, and both post codes 1 (÷2), with no change pulse. Register reads then return 0x64 at address 0, 0x12 at address 1 and 0x00 at address 2.
- R2: Register layout:
  - Address 0 holds feedback bits [7:0].
  - Address 1 holds pre-select in bit 7, post code B in bits 6:4, post code A in bits 3:1 and feedback bit 8 in bit 0.
  - Address 2 holds feedback bit 9 in bit 0; its other bits read as zero.
- R3: Address 3 reads the synchronized lock input in bit 0 and zeros in bits 7:1. Writes to address 3 change no register.
- R4: With pin mode low, a register write appears on the effective outputs one clock after the edge that stores it.
- R5: With pin mode high, pin values appear on the effective outputs three clock edges after they are applied: two synchronizer stages plus the output register.
- R6: While pin mode is high, register writes leave the effective outputs and the change pulse untouched.
- R7: A read always returns the stored register contents, including while the pins override them.
- R8: `cfg_update` is high for exactly one cycle when the effective configuration takes a new value, in the same cycle as the new value. It stays low otherwise, including when a write stores an identical value.
- R9: Read data is presented with `bus_rvalid` high in the cycle after `bus_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_mode | input | 1 | High selects pin-sourced configuration (asynchronous) |
| pin_fb_div | input | 10 | Feedback divider pins |
| pin_pre_sel | input | 1 | Pre-divider select pin |
| pin_post_a | input | 3 | Post-divider code pins, channel A |
| pin_post_b | input | 3 | Post-divider code pins, channel B |
| lock_in | input | 1 | PLL lock indication (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| eff_fb_div | output | 10 | Effective feedback divider |
| eff_pre_sel | output | 1 | Effective pre-divider select |
| eff_post_a | output | 3 | Effective post code, channel A |
| eff_post_b | output | 3 | Effective post code, channel B |
| cfg_update | output | 1 | One-cycle change pulse |

## Verification
The bench writes registers while pin mode is high. A design that let the bank leak through the override would move the dividers or pulse the change flag. A design that routed reads through the effective value would return pin values instead of stored bytes.

It counts change pulses over whole windows. This catches the following faults:
- a design that pulses on every write;
- a design that holds the pulse for more than one cycle;
- a design that misses the pulse when pin mode drops and the register values take over.

The bench also samples the cycles just before and just after the expected latency on both paths. This exposes a missing or extra synchronizer stage. Split-field writes to address 1 and address 2, and a write to the status address, check bit placement and read-only handling.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam int FB_W   = 10;
  localparam int POST_W = 3;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_FB_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_MIX   = 2'd1;
  localparam logic [ADDR_W-1:0] A_FB_HI = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

  typedef struct packed {
    logic [FB_W-1:0]   fb;
    logic              pre;
    logic [POST_W-1:0] pa;
    logic [POST_W-1:0] pb;
  } pll_cfg_t;

  localparam int CFG_W = $bits(pll_cfg_t);

  localparam pll_cfg_t CFG_RESET = '{fb: 10'd100, pre: 1'b0, pa: 3'd1, pb: 3'd1};

  // Address 1 byte: {pre, pb, pa, fb[8]}
  function automatic logic [BYTE_W-1:0] pack_mix(input pll_cfg_t c);
    return {c.pre, c.pb, c.pa, c.fb[8]};
  endfunction

  function automatic pll_cfg_t apply_write(input pll_cfg_t c,
                                           input logic [ADDR_W-1:0] a,
                                           input logic [BYTE_W-1:0] d);
    pll_cfg_t r;
    r = c;
    case (a)
      A_FB_LO: r.fb[7:0] = d;
      A_MIX: begin
        r.pre   = d[7];
        r.pb    = d[6:4];
        r.pa    = d[3:1];
        r.fb[8] = d[0];
      end
      A_FB_HI: r.fb[9] = d[0];
      default: r = c;
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] read_byte(input pll_cfg_t c,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic lock);
    logic [BYTE_W-1:0] b;
    case (a)
      A_FB_LO: b = c.fb[7:0];
      A_MIX:   b = pack_mix(c);
      A_FB_HI: b = {{(BYTE_W-1){1'b0}}, c.fb[9]};
      default: b = {{(BYTE_W-1){1'b0}}, lock};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lock_s,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid,
  output pll_cfg_t          cfg_q
);
  logic wr_ev;
  logic rd_ev;
  assign wr_ev = wr;
  assign rd_ev = rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr_ev) cfg_q <= apply_write(cfg_q, addr, wdata);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_ev;
      if (rd_ev) rdata <= read_byte(cfg_q, addr, lock_s);
    end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(cfg_q)); // R2
  AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && addr == A_STAT) |=> $stable(cfg_q)); // R3
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> rvalid); // R9
  AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> !rvalid); // R9
endmodule

// File: rtl/cfg_select_track.sv
module cfg_select_track
  import pll_cfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_sel,
  input  pll_cfg_t pin_cfg,
  input  pll_cfg_t reg_cfg,
  output pll_cfg_t eff_q,
  output logic     upd_q
);
  pll_cfg_t nxt;
  logic     differs;

  assign nxt     = pin_sel ? pin_cfg : reg_cfg;
  assign differs = (nxt != eff_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      eff_q <= CFG_RESET;
      upd_q <= 1'b0;
    end else begin
      eff_q <= nxt;
      upd_q <= differs;
    end

  AST_UPD_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (eff_q != $past(eff_q))); // R8
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(eff_q)); // R8
  AST_PIN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel |=> (eff_q == $past(pin_cfg))); // R5
  AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_sel |=> (eff_q == $past(reg_cfg))); // R4
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_mode,
  input  logic [FB_W-1:0]   pin_fb_div,
  input  logic              pin_pre_sel,
  input  logic [POST_W-1:0] pin_post_a,
  input  logic [POST_W-1:0] pin_post_b,
  input  logic              lock_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [FB_W-1:0]   eff_fb_div,
  output logic              eff_pre_sel,
  output logic [POST_W-1:0] eff_post_a,
  output logic [POST_W-1:0] eff_post_b,
  output logic              cfg_update
);
  localparam int SW = CFG_W + 2;

  pll_cfg_t         pin_raw, pin_s, reg_cfg, eff;
  logic             mode_s, lock_s;
  logic [SW-1:0]    sync_out;

  assign pin_raw = '{fb: pin_fb_div, pre: pin_pre_sel, pa: pin_post_a, pb: pin_post_b};

  cfg_pin_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({pin_mode, lock_in, pin_raw}),
    .d_sync(sync_out)
  );
  assign {mode_s, lock_s, pin_s} = sync_out;

  cfg_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .lock_s(lock_s), .rdata(bus_rdata), .rvalid(bus_rvalid), .cfg_q(reg_cfg)
  );

  cfg_select_track u_track (
    .clk(clk), .rst_n(rst_n),
    .pin_sel(mode_s), .pin_cfg(pin_s), .reg_cfg(reg_cfg),
    .eff_q(eff), .upd_q(cfg_update)
  );

  assign eff_fb_div  = eff.fb;
  assign eff_pre_sel = eff.pre;
  assign eff_post_a  = eff.pa;
  assign eff_post_b  = eff.pb;

  AST_OVERRIDE_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && $past(mode_s) && $stable(pin_s)) |=> !cfg_update); // R6
endmodule

// File: tb/tb_pll_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_pll_cfg_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       pin_mode = 0, pin_pre_sel = 0, lock_in = 0;
  logic [9:0] pin_fb_div = 0;
  logic [2:0] pin_post_a = 0, pin_post_b = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, eff_pre_sel, cfg_update;
  logic [9:0] eff_fb_div;
  logic [2:0] eff_post_a, eff_post_b;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_cfg_ctrl dut (.*);

  always @(negedge clk) if (cfg_update) pulses++;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk("R9 rvalid", bus_rvalid, 1);
    d = bus_rdata;
    @(negedge clk);
    chk("R9 rvalid drop", bus_rvalid, 0);
  endtask

  task automatic chk_eff(string req, int m, int p, int a, int b);
    chk({req, " fb"}, eff_fb_div, m);
    chk({req, " pre"}, eff_pre_sel, p);
    chk({req, " pa"}, eff_post_a, a);
    chk({req, " pb"}, eff_post_b, b);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk_eff("R1 reset", 'h064, 0, 1, 1);
    chk("R1 no pulse", pulses, 0);
    rd(0, d); chk("R1 addr0", d, 'h64);
    rd(1, d); chk("R1 addr1", d, 'h12);
    rd(2, d); chk("R1 addr2", d, 'h00);
  endtask

  task automatic t_reg_path();
    logic [7:0] d;
    int p0;
    p0 = pulses;
    wr(0, 8'hA5);                       // R4: effective one edge after store
    chk("R4 before", eff_fb_div, 'h064);
    chk("R8 pulse high", cfg_update, 0);
    @(negedge clk);
    chk("R4 after", eff_fb_div, 'h0A5);
    chk("R8 pulse high", cfg_update, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", cfg_update, 0);
    wr(1, 8'hD7); cyc(2);               // R2: P=1 NB=5 NA=3 fb8=1
    wr(2, 8'hFF); cyc(2);               // R2: only bit0 stored
    chk_eff("R2 fields", 'h3A5, 1, 3, 5);
    rd(1, d); chk("R2 addr1", d, 'hD7);
    rd(2, d); chk("R2 addr2 upper zero", d, 'h01);
    chk("R8 three pulses", pulses - p0, 3);
    p0 = pulses;
    wr(0, 8'hA5); cyc(3);
    chk("R8 same value no pulse", pulses - p0, 0);
  endtask

  task automatic t_status();
    logic [7:0] d;
    lock_in = 1; cyc(3);
    rd(3, d); chk("R3 lock set", d, 'h01);
    wr(3, 8'hFE); cyc(2);
    rd(0, d); chk("R3 wr ignored a0", d, 'hA5);
    rd(1, d); chk("R3 wr ignored a1", d, 'hD7);
    rd(2, d); chk("R3 wr ignored a2", d, 'h01);
    rd(3, d); chk("R3 status after wr", d, 'h01);
    lock_in = 0; cyc(3);
    rd(3, d); chk("R3 lock clear", d, 'h00);
  endtask

  task automatic t_pin_path();
    int p0;
    p0 = pulses;
    pin_fb_div = 10'h2C3; pin_pre_sel = 0; pin_post_a = 6; pin_post_b = 7;
    pin_mode = 1;
    @(negedge clk); chk("R5 lat1", eff_fb_div, 'h3A5);
    @(negedge clk); chk("R5 lat2", eff_fb_div, 'h3A5);
    @(negedge clk); chk_eff("R5 pins", 'h2C3, 0, 6, 7);
    chk("R8 pin pulse", cfg_update, 1);
    cyc(2);
    pin_fb_div = 10'h001; cyc(4);
    chk("R5 pin change", eff_fb_div, 'h001);
    chk("R8 two pin pulses", pulses - p0, 2);
  endtask

  task automatic t_override();
    logic [7:0] d;
    int p0;
    p0 = pulses;
    wr(0, 8'h11); cyc(3);
    chk_eff("R6 unchanged", 'h001, 0, 6, 7);
    chk("R6 no pulse", pulses - p0, 0);
    rd(0, d); chk("R7 stored read", d, 'h11);
    rd(1, d); chk("R7 stored read a1", d, 'hD7);
    pin_mode = 0; cyc(4);
    chk_eff("R4 back to regs", 'h311, 1, 3, 5);
    chk("R8 release pulse", pulses - p0, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(3);
    t_reset();
    t_reg_path();
    t_status();
    t_pin_path();
    t_override();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule